// File: doc/BRIEF.md
# UART Channel FIFO Pair with Trigger-Level Interrupts

This block holds the receive and transmit character buffers of one UART channel. Each direction has a 64-entry first-in first-out store with a push port on one side and a pop port on the other. The receive store keeps three per-character error flags next to every data byte, so line errors stay attached to the character they belong to until the host reads it.

Each direction raises its own interrupt request when its fill state reaches a threshold. On the receive side the threshold is a count of stored characters. On the transmit side it is a count of free spaces. The threshold comes from one of two sources. The first is a coarse 2-bit selection code. The second is a finer 4-bit programmable value, which wins whenever it is nonzero. While the FIFOs are disabled, both thresholds fall back to a single character.

A per-direction clear input empties that store in one cycle and leaves the other store alone. The serial shifter, the baud generator and the host register decoding sit outside this block.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each direction stores up to 64 entries and returns them in push order. A pop of a non-empty store updates the read data at the same clock edge that lowers the level output. A push is accepted when the level is below 64, even if a pop happens in the same cycle.
- R2: A receive entry is 11 bits wide: the 8-bit data byte together with its 3 error flags. The flags pushed with a byte come back on the error output with that byte.
- R3: While `fifo_en` is low, the receive threshold is 1 stored character and the transmit threshold is 1 free space. This holds whatever the code and programmable inputs are.
- R4: With `fifo_en` high and `rx_prog` zero, `rx_code` values 0, 1, 2 and 3 give receive thresholds of 8, 16, 56 and 60 characters.
- R5: With `fifo_en` high and `tx_prog` zero, `tx_code` values 0, 1, 2 and 3 give transmit thresholds of 8, 16, 32 and 56 free spaces.
- R6: With `fifo_en` high, a nonzero programmable value N overrides the code for that direction and gives a threshold of 4×N. The receive and transmit selections are independent of each other.
- R7: `rx_irq` is high exactly when `rx_level` is at or above the receive threshold. It updates at the same edge as `rx_level`, using the configuration present at that edge.
- R8: `tx_irq` is high exactly when 64 minus `tx_level` is at or above the transmit threshold. It updates at the same edge as `tx_level`.
- R9: A receive push while `rx_level` is 64 is dropped and sets `rx_ovr`. `rx_ovr` then stays high until reset or `rx_clr`. A transmit push while `tx_level` is 64 is also dropped.
- R10: A pop while the level is 0 leaves the read data and the level unchanged. If a push happens in the same cycle, the pushed entry is still stored.
- R11: `rx_clr` or `tx_clr` sets that direction's level to 0 at the next edge, ignores that direction's push and pop in the same cycle, leaves the other direction untouched, and keeps the read data. `rx_clr` also clears `rx_ovr`.
- R12: After reset both levels are 0, `rx_irq` is 0, `tx_irq` is 1, `rx_ovr` is 0, and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable; when low both thresholds are 1 |
| rx_code | input | 2 | Coarse receive threshold selection |
| rx_prog | input | 4 | Programmable receive threshold in units of 4; 0 selects the code |
| tx_code | input | 2 | Coarse transmit threshold selection |
| tx_prog | input | 4 | Programmable transmit threshold in units of 4; 0 selects the code |
| rx_clr | input | 1 | Empty the receive store |
| tx_clr | input | 1 | Empty the transmit store |
| rx_push | input | 1 | Write one receive entry |
| rx_wdata | input | 8 | Receive data byte to write |
| rx_werr | input | 3 | Error flags for the byte being written |
| rx_pop | input | 1 | Read one receive entry |
| rx_rdata | output | 8 | Last popped receive byte |
| rx_rerr | output | 3 | Error flags of the last popped receive byte |
| rx_level | output | 7 | Stored receive entries |
| rx_irq | output | 1 | Receive threshold reached |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_push | input | 1 | Write one transmit byte |
| tx_wdata | input | 8 | Transmit byte to write |
| tx_pop | input | 1 | Read one transmit byte |
| tx_rdata | output | 8 | Last popped transmit byte |
| tx_level | output | 7 | Stored transmit entries |
| tx_irq | output | 1 | Transmit free-space threshold reached |

## Verification
The bench uses the default depth of 64 with 8 data bits and 3 error bits. At that depth every coarse code and every programmable value from 4 to 60 is a threshold the fill level can actually reach. The full and empty boundaries are also reachable in a few dozen cycles, so overrun, pops on an empty store and the irq crossing at each threshold all come up both in directed steps and in random traffic. Keeping the depth at 64 also means the 60-character receive code and the 56-space transmit code sit close to the full and empty ends, where the off-by-one risks are.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } fifo_dir_e;

  // Coarse threshold table per direction
  function automatic int unsigned coarse_level(fifo_dir_e dir, logic [1:0] code);
    if (dir == DIR_RX) begin
      case (code)
        2'd0:    return 8;
        2'd1:    return 16;
        2'd2:    return 56;
        default: return 60;
      endcase
    end else begin
      case (code)
        2'd0:    return 8;
        2'd1:    return 16;
        2'd2:    return 32;
        default: return 56;
      endcase
    end
  endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    count_nxt
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, wr_ok, rd_ok;

  assign full  = (count == FULL_C);
  assign empty = (count == '0);
  assign wr_ok = push && !full && !clr;
  assign rd_ok = pop && !empty && !clr;

  always_comb begin
    if (clr)                count_nxt = '0;
    else if (wr_ok && !rd_ok) count_nxt = count + 1'b1;
    else if (rd_ok && !wr_ok) count_nxt = count - 1'b1;
    else                    count_nxt = count;
  end

  // Storage array: no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_ok) begin
      rdata <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (wr_ok) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_C); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr && full) |=> (count == FULL_C)); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !clr && empty) |=> ($stable(rdata) && count == '0)); // R10
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && $stable(rdata))); // R11

endmodule

// File: rtl/trig_select.sv
module trig_select
  import uart_fifo_pkg::*;
#(
  parameter fifo_dir_e DIR = DIR_RX,
  parameter int        CW  = 7
) (
  input  logic          en,
  input  logic [1:0]    code,
  input  logic [3:0]    prog,
  output logic [CW-1:0] level
);

  logic [CW-1:0] coarse;

  generate
    if (DIR == DIR_RX) begin : g_rx
      always_comb coarse = CW'(coarse_level(DIR_RX, code));
    end else begin : g_tx
      always_comb coarse = CW'(coarse_level(DIR_TX, code));
    end
  endgenerate

  always_comb begin
    if (!en)              level = CW'(1);
    else if (prog != 4'd0) level = CW'({prog, 2'b00});
    else                  level = coarse;
  end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = DW + EW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [1:0]    rx_code,
  input  logic [3:0]    rx_prog,
  input  logic [1:0]    tx_code,
  input  logic [3:0]    tx_prog,
  input  logic          rx_clr,
  input  logic          tx_clr,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic [EW-1:0] rx_werr,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [EW-1:0] rx_rerr,
  output logic [CW-1:0] rx_level,
  output logic          rx_irq,
  output logic          rx_ovr,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic [CW-1:0] tx_level,
  output logic          tx_irq
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [RW-1:0] rx_word;
  logic [CW-1:0] rx_nxt, tx_nxt, rx_trig, tx_trig;

  fifo_store #(.DEPTH(DEPTH), .WIDTH(RW)) u_rx_store (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .wdata({rx_werr, rx_wdata}), .pop(rx_pop),
    .rdata(rx_word), .count(rx_level), .count_nxt(rx_nxt)
  );

  assign rx_rdata = rx_word[DW-1:0];
  assign rx_rerr  = rx_word[RW-1:DW];

  fifo_store #(.DEPTH(DEPTH), .WIDTH(DW)) u_tx_store (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_level), .count_nxt(tx_nxt)
  );

  trig_select #(.DIR(DIR_RX), .CW(CW)) u_rx_trig (
    .en(fifo_en), .code(rx_code), .prog(rx_prog), .level(rx_trig)
  );

  trig_select #(.DIR(DIR_TX), .CW(CW)) u_tx_trig (
    .en(fifo_en), .code(tx_code), .prog(tx_prog), .level(tx_trig)
  );

  // Registered requests, aligned with the level registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b1;
    end else begin
      rx_irq <= (rx_nxt >= rx_trig);
      tx_irq <= ((FULL_C - tx_nxt) >= tx_trig);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rx_clr)                        rx_ovr <= 1'b0;
    else if (rx_push && rx_level == FULL_C)   rx_ovr <= 1'b1;
  end

  AST_RX_IRQ_LVL: assert property (@(posedge clk) disable iff (rst)
    rx_irq == (rx_level >= $past(rx_trig))); // R7
  AST_TX_IRQ_SPACE: assert property (@(posedge clk) disable iff (rst)
    tx_irq == ((FULL_C - tx_level) >= $past(tx_trig))); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !rx_clr) |=> rx_ovr); // R9
  AST_TRIG_FLOOR: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (rx_trig == CW'(1) && tx_trig == CW'(1))); // R3

endmodule

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/1ps
module uart_fifo_pair_bench;

  localparam int DEPTH = 64;
  localparam int MAX_CYC = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0;
  logic [1:0] rx_code = '0, tx_code = '0;
  logic [3:0] rx_prog = '0, tx_prog = '0;
  logic rx_clr = 1'b0, tx_clr = 1'b0;
  logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_wdata = '0, tx_wdata = '0;
  logic [2:0] rx_werr = '0;
  logic [7:0] rx_rdata, tx_rdata;
  logic [2:0] rx_rerr;
  logic [6:0] rx_level, tx_level;
  logic rx_irq, rx_ovr, tx_irq;

  always #2 clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (
    .clk(clk), .rst(rst), .fifo_en(fifo_en),
    .rx_code(rx_code), .rx_prog(rx_prog), .tx_code(tx_code), .tx_prog(tx_prog),
    .rx_clr(rx_clr), .tx_clr(tx_clr),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_werr(rx_werr), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_rerr(rx_rerr), .rx_level(rx_level),
    .rx_irq(rx_irq), .rx_ovr(rx_ovr),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_level(tx_level), .tx_irq(tx_irq)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference model
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  logic [10:0] e_rx_word = '0;
  logic [7:0]  e_tx_data = '0;
  bit e_ovr = 1'b0, e_rx_irq = 1'b0, e_tx_irq = 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rx_thr();
    if (!fifo_en) return 1;
    if (rx_prog != 0) return 4 * int'(rx_prog);
    case (rx_code)
      2'd0: return 8;  2'd1: return 16;
      2'd2: return 56; default: return 60;
    endcase
  endfunction

  function automatic int tx_thr();
    if (!fifo_en) return 1;
    if (tx_prog != 0) return 4 * int'(tx_prog);
    case (tx_code)
      2'd0: return 8;  2'd1: return 16;
      2'd2: return 32; default: return 56;
    endcase
  endfunction

  function automatic string rx_tag();
    if (!fifo_en) return "R3/R7 rx_irq";
    return (rx_prog != 0) ? "R6/R7 rx_irq" : "R4/R7 rx_irq";
  endfunction

  function automatic string tx_tag();
    if (!fifo_en) return "R3/R8 tx_irq";
    return (tx_prog != 0) ? "R6/R8 tx_irq" : "R5/R8 tx_irq";
  endfunction

  task automatic check_all();
    chk("R1 rx_level", int'(rx_level), rxq.size());
    chk("R1 tx_level", int'(tx_level), txq.size());
    chk("R1 rx_rdata", int'(rx_rdata), int'(e_rx_word[7:0]));
    chk("R2 rx_rerr",  int'(rx_rerr),  int'(e_rx_word[10:8]));
    chk("R1 tx_rdata", int'(tx_rdata), int'(e_tx_data));
    chk(rx_tag(), int'(rx_irq), int'(e_rx_irq));
    chk(tx_tag(), int'(tx_irq), int'(e_tx_irq));
    chk("R9 rx_ovr", int'(rx_ovr), int'(e_ovr));
  endtask

  // Called at a falling edge: drive, model the next rising edge, check at the next falling edge
  task automatic step(input bit rp, input bit rpo, input bit tp, input bit tpo,
                      input bit rc, input bit tc);
    int rn, tn;
    rx_push = rp; rx_pop = rpo; tx_push = tp; tx_pop = tpo;
    rx_clr = rc; tx_clr = tc;
    rx_wdata = 8'($urandom); rx_werr = 3'($urandom); tx_wdata = 8'($urandom);
    rn = rxq.size(); tn = txq.size();
    if (rc) begin
      rxq.delete(); e_ovr = 1'b0;
    end else begin
      if (rp && rn == DEPTH) e_ovr = 1'b1;
      if (rpo && rn > 0) e_rx_word = rxq.pop_front();
      if (rp && rn < DEPTH) rxq.push_back({rx_werr, rx_wdata});
    end
    if (tc) begin
      txq.delete();
    end else begin
      if (tpo && tn > 0) e_tx_data = txq.pop_front();
      if (tp && tn < DEPTH) txq.push_back(tx_wdata);
    end
    e_rx_irq = (rxq.size() >= rx_thr());
    e_tx_irq = ((DEPTH - txq.size()) >= tx_thr());
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rx_clr = 0; tx_clr = 0;
    check_all();
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h1A2B3C);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 rx_level", int'(rx_level), 0);
    chk("R12 tx_level", int'(tx_level), 0);
    chk("R12 rx_irq", int'(rx_irq), 0);
    chk("R12 tx_irq", int'(tx_irq), 1);
    chk("R12 rx_ovr", int'(rx_ovr), 0);
    chk("R12 rx_rdata", int'(rx_rdata), 0);

    // R3: disabled, one-character thresholds despite other codes
    rx_code = 2'd3; tx_code = 2'd3; rx_prog = 4'd9;
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);                 // rx_irq rises at 1 entry
    for (int i = 0; i < 63; i++) step(0, 0, 1, 0, 0, 0);
    chk("R3 tx_irq one space left", int'(tx_irq), 1);
    step(0, 0, 1, 0, 0, 0);
    chk("R3 tx_irq no space", int'(tx_irq), 0);
    step(0, 0, 1, 0, 0, 0);                 // R9 tx push into full dropped
    chk("R9 tx full drop", int'(tx_level), 64);

    // R11 independent clear
    step(0, 0, 0, 0, 0, 1);
    chk("R11 tx cleared", int'(tx_level), 0);
    chk("R11 rx untouched", int'(rx_level), 1);

    // R4 coarse rx sweep, filling to 64 then overrun
    fifo_en = 1'b1; rx_prog = 4'd0;
    for (int c = 0; c < 4; c++) begin
      rx_code = 2'(c);
      step(0, 0, 0, 0, 0, 0);
    end
    for (int i = 0; i < 63; i++) begin
      rx_code = 2'(i % 4);
      step(1, 0, 0, 0, 0, 0);
    end
    step(1, 1, 0, 0, 0, 0);                 // full: push dropped, pop ok, R9
    chk("R9 overrun on full", int'(rx_ovr), 1);
    for (int i = 0; i < 70; i++) step(0, 1, 0, 0, 0, 0); // drain past empty, R10
    chk("R10 empty pop level", int'(rx_level), 0);
    step(1, 1, 0, 0, 0, 0);                 // empty push+pop: push kept
    chk("R10 push kept on empty pop", int'(rx_level), 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R11 rx_ovr cleared", int'(rx_ovr), 0);

    // R5/R6 tx sweep
    for (int i = 0; i < 60; i++) begin
      tx_code = 2'(i % 4);
      tx_prog = (i % 3 == 0) ? 4'(i % 16) : 4'd0;
      rx_prog = 4'((i * 7) % 16);
      step(i % 5 != 0, 0, 1, 0, 0, 0);
    end

    // Random traffic
    for (int seg = 0; seg < 60; seg++) begin
      int bias;
      bias = int'($urandom_range(1, 7));
      fifo_en = ($urandom_range(0, 7) != 0);
      rx_code = 2'($urandom); tx_code = 2'($urandom);
      rx_prog = ($urandom_range(0, 1) != 0) ? 4'($urandom) : 4'd0;
      tx_prog = ($urandom_range(0, 1) != 0) ? 4'($urandom) : 4'd0;
      for (int k = 0; k < 50; k++)
        step($urandom_range(0, 7) < bias, $urandom_range(0, 7) >= bias,
             $urandom_range(0, 7) >= bias, $urandom_range(0, 7) < bias,
             $urandom_range(0, 99) == 0, $urandom_range(0, 99) == 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule